// File: doc/BRIEF.md
# March C- Memory Self-Test Controller

This block drives a single-port synchronous SRAM through the six-element March C- sequence and grades every read on the fly. After a start request it walks the address space six times, in both directions, with the read/write pairs the algorithm defines. It writes the all-zeros or all-ones word, and it checks each read word against the value the algorithm expects at that step.

Read data is graded one cycle after the read is issued, which matches a memory with one cycle of read latency. The first mismatch freezes a small log: the failing address, the element number and the expected word. A sticky fail flag is set, and the sequence still runs to its end, so the test always takes the same number of cycles. When the final read of the last element has been graded, done rises, and pass reports whether the memory came through clean. The controller is meant to sit next to one embedded memory. A higher level pulses start and then waits for done.

Top module: `mbist_marchc`

## Requirements
- R1: During and after reset, done, pass and fail are 0 and neither mem_we nor mem_re is asserted.
- R2: Element 1 issues one write per cycle of the all-zeros word to every address from 0 up to DEPTH-1.
- R3: Elements 2 and 3 walk addresses upward. At each address they issue a read in one cycle and a write in the next: element 2 expects all-zeros and writes all-ones, and element 3 expects all-ones and writes all-zeros.
- R4: Elements 4 and 5 walk addresses downward from DEPTH-1 to 0. They use the same read-then-write pairing as R3: element 4 expects zeros and writes ones, and element 5 expects ones and writes zeros.
- R5: Element 6 issues one read per cycle from address 0 up to DEPTH-1, expecting all-zeros.
- R6: A run issues exactly 10×DEPTH memory operations on consecutive cycles. The first is presented in the cycle after the clock edge that samples start. done rises at the edge that follows the edge after the last operation, and no access occurs while done is high.
- R7: A cycle never carries both a read and a write. Outside a run, no access is issued.
- R8: The read word is compared against the expected value in the cycle after the read. pass is 1 at done only if every compare matched.
- R9: The first mismatch sets fail and records the address, the element number (1 to 6, in the order given by R2–R5) and the expected word. Later mismatches in the same run leave the record unchanged.
- R10: start is ignored while a run is in progress. start while idle or done begins a new run and clears done, fail and the record at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run when idle or done |
| done | output | 1 | Run finished; held until the next start |
| pass | output | 1 | Run finished with no mismatch |
| fail | output | 1 | Sticky mismatch flag for the current run |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | DATA_W | Memory write word |
| mem_rdata | input | DATA_W | Memory read word, valid the cycle after mem_re |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 3 | Element number (1 to 6) of the first mismatch |
| fail_expect | output | DATA_W | Expected word at the first mismatch |

## Verification
The bench models the memory with stuck-at cells and with an up-transition coupling fault, including faults placed at address 0 and at DEPTH-1. It predicts the first failing step by replaying the algorithm on its own copy of the array. A controller that graded reads a cycle early or late would report spurious failures on a clean memory. One that walked the down-going elements in the wrong direction would miss or misplace coupling faults whose aggressor lies above the victim. One that let later mismatches overwrite the record would report element 4 or 6 instead of element 2 for a stuck-at-one cell. A start pulse in the middle of a run checks that the operation trace is not disturbed. A restart after a failed run checks that the record and flags are cleared.

// File: rtl/mbist_pkg.sv
`timescale 1ns/1ps
package mbist_pkg;

    // Element numbers are reported in the failure log, so the values matter.
    typedef enum logic [2:0] {
        EL_NONE    = 3'd0,
        EL_W0      = 3'd1,
        EL_UP_R0W1 = 3'd2,
        EL_UP_R1W0 = 3'd3,
        EL_DN_R0W1 = 3'd4,
        EL_DN_R1W0 = 3'd5,
        EL_UP_R0   = 3'd6
    } march_elem_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH,
        ST_DONE
    } seq_state_e;

    // One memory operation; 'one' selects the all-ones word (write data or expected data).
    typedef struct packed {
        logic rd;
        logic wr;
        logic one;
    } mem_op_t;

    // Tag travelling with a read to the compare stage.
    typedef struct packed {
        logic        valid;
        logic        one;
        logic [2:0]  elem;
    } rd_tag_t;

    function automatic logic elem_has_read(input march_elem_e e);
        return (e != EL_W0) && (e != EL_NONE);
    endfunction

    function automatic logic elem_has_write(input march_elem_e e);
        return (e != EL_UP_R0) && (e != EL_NONE);
    endfunction

    function automatic logic elem_down(input march_elem_e e);
        return (e == EL_DN_R0W1) || (e == EL_DN_R1W0);
    endfunction

    function automatic logic elem_read_val(input march_elem_e e);
        return (e == EL_UP_R1W0) || (e == EL_DN_R1W0);
    endfunction

    function automatic logic elem_write_val(input march_elem_e e);
        return (e == EL_UP_R0W1) || (e == EL_DN_R0W1);
    endfunction

    function automatic march_elem_e elem_next(input march_elem_e e);
        case (e)
            EL_W0:      return EL_UP_R0W1;
            EL_UP_R0W1: return EL_UP_R1W0;
            EL_UP_R1W0: return EL_DN_R0W1;
            EL_DN_R0W1: return EL_DN_R1W0;
            EL_DN_R1W0: return EL_UP_R0;
            default:    return EL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
`timescale 1ns/1ps
module mbist_addr_gen #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              load_down,
    input  logic              step,
    input  logic              down,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_down ? TOP_ADDR : '0;
        end else if (step) begin
            addr <= down ? addr - ADDR_W'(1) : addr + ADDR_W'(1);
        end
    end

    assign last = down ? (addr == '0) : (addr == TOP_ADDR);

endmodule

// File: rtl/mbist_seq.sv
`timescale 1ns/1ps
module mbist_seq
    import mbist_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        addr_last,
    output logic        accept,
    output logic        load,
    output logic        load_down,
    output logic        step,
    output logic        down,
    output mem_op_t     op,
    output march_elem_e elem,
    output logic        done
);
    seq_state_e state;
    logic       phase;
    logic       pair;
    logic       op_end;

    assign accept = start && ((state == ST_IDLE) || (state == ST_DONE));
    assign pair   = elem_has_read(elem) && elem_has_write(elem);
    assign op_end = (state == ST_RUN) && (!pair || phase);
    assign down   = elem_down(elem);
    assign done   = (state == ST_DONE);

    always_comb begin
        op = '0;
        if (state == ST_RUN) begin
            op.rd  = elem_has_read(elem) && !phase;
            op.wr  = elem_has_write(elem) && (!elem_has_read(elem) || phase);
            op.one = op.rd ? elem_read_val(elem) : elem_write_val(elem);
        end
    end

    assign step      = op_end && !addr_last;
    assign load      = accept || (op_end && addr_last && (elem != EL_UP_R0));
    assign load_down = accept ? 1'b0 : elem_down(elem_next(elem));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            elem  <= EL_NONE;
            phase <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state <= ST_RUN;
                        elem  <= EL_W0;
                        phase <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (op_end) begin
                        phase <= 1'b0;
                        if (addr_last) begin
                            if (elem == EL_UP_R0) begin
                                state <= ST_FLUSH;
                                elem  <= EL_NONE;
                            end else begin
                                elem <= elem_next(elem);
                            end
                        end
                    end else begin
                        phase <= 1'b1;
                    end
                end
                ST_FLUSH: state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mbist_resp.sv
`timescale 1ns/1ps
module mbist_resp
    import mbist_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              issue,
    input  logic              exp_one,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [2:0]        issue_elem,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [2:0]        fail_elem,
    output logic              fail_one
);
    rd_tag_t           tag_q;
    logic [ADDR_W-1:0] addr_q;
    logic              mismatch;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tag_q  <= '0;
            addr_q <= '0;
        end else begin
            tag_q.valid <= issue;
            tag_q.one   <= exp_one;
            tag_q.elem  <= issue_elem;
            addr_q      <= issue_addr;
        end
    end

    assign mismatch = tag_q.valid && (rdata != {DATA_W{tag_q.one}});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
            fail_one  <= 1'b0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr_q;
            fail_elem <= tag_q.elem;
            fail_one  <= tag_q.one;
        end
    end

endmodule

// File: rtl/mbist_marchc.sv
`timescale 1ns/1ps
module mbist_marchc
    import mbist_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [2:0]        fail_elem,
    output logic [DATA_W-1:0] fail_expect
);
    mem_op_t     op;
    march_elem_e elem;
    logic        accept, load, load_down, step, down, addr_last;
    logic        fail_one;

    mbist_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .addr_last (addr_last),
        .accept    (accept),
        .load      (load),
        .load_down (load_down),
        .step      (step),
        .down      (down),
        .op        (op),
        .elem      (elem),
        .done      (done)
    );

    mbist_addr_gen #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_down (load_down),
        .step      (step),
        .down      (down),
        .addr      (mem_addr),
        .last      (addr_last)
    );

    mbist_resp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .issue      (op.rd),
        .exp_one    (op.one),
        .issue_addr (mem_addr),
        .issue_elem (3'(elem)),
        .rdata      (mem_rdata),
        .fail       (fail),
        .fail_addr  (fail_addr),
        .fail_elem  (fail_elem),
        .fail_one   (fail_one)
    );

    assign mem_we      = op.wr;
    assign mem_re      = op.rd;
    assign mem_wdata   = (op.wr && op.one) ? '1 : '0;
    assign fail_expect = {DATA_W{fail_one}};
    assign pass        = done && !fail;

endmodule

// File: rtl/mbist_marchc_sva.sv
`timescale 1ns/1ps
module mbist_marchc_sva #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [2:0]        fail_elem,
    input logic [DATA_W-1:0] fail_expect
);
    p_no_rw_clash_r7: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    p_addr_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> (mem_addr <= ADDR_W'(DEPTH - 1)));

    p_wdata_solid_r2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_wdata == '0) || (mem_wdata == '1)));

    p_quiet_when_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_we && !mem_re));

    p_pass_clean_r8: assert property (@(posedge clk) disable iff (rst)
        pass |-> (done && !fail));

    p_fail_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

    p_log_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> ($stable(fail_addr) && $stable(fail_elem) && $stable(fail_expect)));

    p_elem_valid_r9: assert property (@(posedge clk) disable iff (rst)
        fail |-> ((fail_elem >= 3'd1) && (fail_elem <= 3'd6)));

    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    p_restart_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (!done && !fail));

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!done && !fail && !mem_we && !mem_re));

endmodule

bind mbist_marchc mbist_marchc_sva #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .done        (done),
    .pass        (pass),
    .fail        (fail),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_wdata   (mem_wdata),
    .fail_addr   (fail_addr),
    .fail_elem   (fail_elem),
    .fail_expect (fail_expect)
);

// File: tb/test_mbist_marchc.sv
`timescale 1ns/1ps
module test_mbist_marchc;
    localparam int DEPTH  = 16;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int NOPS   = 10 * DEPTH;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              done, pass, fail, mem_we, mem_re;
    logic [ADDR_W-1:0] mem_addr, fail_addr;
    logic [DATA_W-1:0] mem_wdata, fail_expect;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [2:0]        fail_elem;

    always #5 clk = ~clk;

    mbist_marchc #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mbist_marchc (
        .clk(clk), .rst(rst), .start(start), .done(done), .pass(pass), .fail(fail),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .fail_addr(fail_addr), .fail_elem(fail_elem),
        .fail_expect(fail_expect)
    );

    int nvec = 0;
    int nbad = 0;

    // Fault model: 0 none, 1 stuck-at cell bit, 2 up-transition coupling (aggressor bit 0->1 flips victim bit)
    int fault_kind = 0;
    int f_cell = 0, f_bit = 0, f_val = 0, f_aggr = 0, f_vict = 0;

    logic [DATA_W-1:0] mem  [DEPTH];
    logic [DATA_W-1:0] rmem [DEPTH];
    int                ma;
    logic [DATA_W-1:0] mold;

    function automatic logic [DATA_W-1:0] stuck(input int a, input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r = d;
        if (fault_kind == 1 && a == f_cell) r[f_bit] = f_val[0];
        return r;
    endfunction

    always @(posedge clk) begin
        ma = int'(mem_addr);
        if (mem_we) begin
            mold    = mem[ma];
            mem[ma] = stuck(ma, mem_wdata);
            if (fault_kind == 2 && ma == f_aggr && !mold[f_bit] && mem[ma][f_bit])
                mem[f_vict][f_bit] = ~mem[f_vict][f_bit];
        end
        if (mem_re) mem_rdata <= stuck(ma, mem[ma]);
    end

    // Expected operation number k of a run, derived from R2..R5.
    function automatic void exp_op(input int k, output logic we, output logic re,
                                   output int addr, output logic one, output int elem);
        int j, e, r, pos;
        if (k < DEPTH) begin
            we = 1; re = 0; addr = k; one = 0; elem = 1;
        end else if (k < 9 * DEPTH) begin
            j = k - DEPTH; e = j / (2 * DEPTH); r = j % (2 * DEPTH); pos = r / 2;
            addr = (e < 2) ? pos : DEPTH - 1 - pos;
            re   = (r % 2 == 0); we = !re;
            // elems 2,4: r0 w1 ; elems 3,5: r1 w0
            one  = (e % 2 == 0) ? we : re;
            elem = 2 + e;
        end else begin
            we = 0; re = 1; addr = k - 9 * DEPTH; one = 0; elem = 6;
        end
    endfunction

    bit   x_fail;
    int   x_addr, x_elem;
    logic x_one;

    task automatic ref_run();
        logic we, re, one;
        int a, el;
        logic [DATA_W-1:0] old, w;
        x_fail = 0; x_addr = 0; x_elem = 0; x_one = 0;
        for (int i = 0; i < DEPTH; i++) rmem[i] = mem[i];
        for (int k = 0; k < NOPS; k++) begin
            exp_op(k, we, re, a, one, el);
            w = one ? '1 : '0;
            if (we) begin
                old     = rmem[a];
                rmem[a] = stuck(a, w);
                if (fault_kind == 2 && a == f_aggr && !old[f_bit] && rmem[a][f_bit])
                    rmem[f_vict][f_bit] = ~rmem[f_vict][f_bit];
            end
            if (re && stuck(a, rmem[a]) != w && !x_fail) begin
                x_fail = 1; x_addr = a; x_elem = el; x_one = one;
            end
        end
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_march(input bit poke);
        logic we, re, one;
        int a, el;
        int bad_e [7];
        int clash = 0;
        for (int i = 0; i < 7; i++) bad_e[i] = 0;
        ref_run();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R10", "done cleared at start", done, 0);
        chk("R10", "fail cleared at start", fail, 0);
        for (int k = 0; k < NOPS; k++) begin
            if (k > 0) @(negedge clk);
            if (poke && k == NOPS / 2 + 1) start = 0;
            exp_op(k, we, re, a, one, el);
            if (mem_we !== we || mem_re !== re || int'(mem_addr) != a ||
                (we && mem_wdata !== (one ? {DATA_W{1'b1}} : {DATA_W{1'b0}})))
                bad_e[el]++;
            if (mem_we && mem_re) clash++;
            if (poke && k == NOPS / 2) start = 1;
        end
        chk("R2", "element 1 trace errors", bad_e[1], 0);
        chk("R3", "elements 2-3 trace errors", bad_e[2] + bad_e[3], 0);
        chk("R4", "elements 4-5 trace errors", bad_e[4] + bad_e[5], 0);
        chk("R5", "element 6 trace errors", bad_e[6], 0);
        chk("R7", "read/write clash cycles", clash, 0);
        if (poke) chk("R10", "mid-run start left trace intact",
                      bad_e[1] + bad_e[2] + bad_e[3] + bad_e[4] + bad_e[5] + bad_e[6], 0);
        @(negedge clk);
        chk("R6", "done low in compare cycle", done, 0);
        chk("R7", "no access after last op", mem_we | mem_re, 0);
        @(negedge clk);
        chk("R6", "done after 10N ops", done, 1);
        chk("R8", "pass verdict", pass, !x_fail);
        chk("R9", "fail flag", fail, x_fail);
        if (x_fail) begin
            chk("R9", "fail_addr", fail_addr, x_addr);
            chk("R9", "fail_elem", fail_elem, x_elem);
            chk("R9", "fail_expect", fail_expect, x_one ? {DATA_W{1'b1}} : {DATA_W{1'b0}});
        end
        repeat (2) @(negedge clk);
        chk("R10", "done held while idle", done, 1);
    endtask

    task automatic set_fault(input int kind, input int c, input int b, input int v, input int ag, input int vi);
        fault_kind = kind; f_cell = c; f_bit = b; f_val = v; f_aggr = ag; f_vict = vi;
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'($urandom);
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", done, 0);
        chk("R1", "fail in reset", fail, 0);
        chk("R1", "access in reset", mem_we | mem_re, 0);
        rst = 0;
        repeat (2) @(negedge clk);
        chk("R1", "idle after reset", {done, pass, fail, mem_we, mem_re}, 0);

        set_fault(0, 0, 0, 0, 0, 0);          run_march(0);
        set_fault(1, 0, 0, 1, 0, 0);          run_march(0);   // stuck-1 at first address
        set_fault(1, DEPTH - 1, DATA_W - 1, 0, 0, 0); run_march(0); // stuck-0 at last address
        set_fault(2, 0, 3, 0, 3, 9);          run_march(0);   // aggressor below victim
        set_fault(2, 0, 1, 0, 12, 2);         run_march(0);   // aggressor above victim
        set_fault(0, 0, 0, 0, 0, 0);          run_march(1);   // start pulse mid-run

        for (int n = 0; n < 16; n++) begin
            int kind, c, b, ag, vi;
            kind = $urandom_range(0, 2);
            c  = $urandom_range(0, DEPTH - 1);
            b  = $urandom_range(0, DATA_W - 1);
            ag = $urandom_range(0, DEPTH - 1);
            vi = (ag + $urandom_range(1, DEPTH - 1)) % DEPTH;
            for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'($urandom);
            set_fault(kind, c, b, $urandom_range(0, 1), ag, vi);
            run_march($urandom_range(0, 1) == 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #2000000;
        nvec++;
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule